// File: doc/BRIEF.md
# Radix-2 Add-Compare-Select Trellis Step

This block carries out one trellis step of a maximum-metric convolutional decoder. It works on the path metrics of all states of a 16-state (constraint length 5) or 64-state (constraint length 7) trellis, which the `K` parameter selects. A start pulse captures the whole path-metric vector and one branch metric per butterfly. The block then splits the captured metrics into an even-state group and an odd-state group. It runs the butterflies in groups of `LANES` per clock, and returns the survivor metrics together with one decision bit per new state.

All arithmetic is signed 16-bit and saturating, and a larger metric is better. Branch metric generation, metric normalization, survivor storage and traceback belong to the surrounding decoder. When `LANES` covers every butterfly, the step takes a single cycle. A smaller `LANES` iterates over several cycles and needs fewer adders and comparators.

Top module: `acs_butterfly_array`

## Requirements
- R1: Every add and subtract saturates to the range [-32768, 32767] and never wraps.
- R2: For butterfly j, with E the metric of state 2j, O the metric of state 2j+1 and b branch metric j, the new metric of state j is max(E+b, O-b).
- R3: For butterfly j, the new metric of state j+S/2 (S = number of states) is max(E-b, O+b).
- R4: The decision bit of each new state is 1 when its even-predecessor candidate is greater than or equal to its odd-predecessor candidate, and 0 otherwise. A tie therefore gives 1.
- R5: State i occupies bits [16i+15:16i] of `pm_i` and `pm_o` and bit i of `dec_o`. Branch metric j occupies bits [16j+15:16j] of `bm_i`. Butterfly j pairs states 2j and 2j+1, so the input is read even/odd deinterleaved.
- R6: A start accepted while idle raises `busy_o` from the next cycle for G = S/2/LANES cycles. `done_o` is then high for exactly one cycle as `busy_o` falls, and `pm_o` and `dec_o` hold the new results from that cycle until the next run updates them.
- R7: `start_i` is ignored while `busy_o` is high. The input vectors may change during a run without affecting its results or its timing.
- R8: After synchronous reset, `busy_o` and `done_o` are 0 and `pm_o` and `dec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one trellis step; sampled only while idle |
| pm_i | input | 16*S | Current path metrics, state i in slice i |
| bm_i | input | 16*S/2 | Branch metrics, butterfly j in slice j |
| busy_o | output | 1 | A step is being computed |
| done_o | output | 1 | One-cycle pulse: results are complete |
| pm_o | output | 16*S | New path metrics, state i in slice i |
| dec_o | output | S | Survivor decision bit per new state |

## Verification
The bench drives candidate pairs that are exactly equal. A design that used a strict greater-than comparison would return 0 instead of 1 on those decision bits. Metrics near both limits with a full-scale branch metric show whether any adder wraps, which would turn a winning metric into a large negative value and flip the selection. A ramp of distinct metrics shows whether states are paired correctly, because any mistake in the even/odd split or the half-array placement moves values to the wrong slice. The bench also runs a 64-state iterated instance and a 16-state single-cycle instance side by side, and re-raises start with changed inputs in mid-run. A design that restarted or re-sampled its inputs would move the done pulse or corrupt the results.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int MW = 16;

    typedef logic signed [MW-1:0] metric_t;

    typedef struct packed {
        metric_t lo;
        metric_t hi;
        logic    dlo;
        logic    dhi;
    } bfly_res_t;

    typedef enum logic {ST_IDLE, ST_RUN} sched_st_t;

    localparam metric_t MET_MAX = 16'sh7fff;
    localparam metric_t MET_MIN = 16'sh8000;

    function automatic metric_t clamp17(logic signed [MW:0] s);
        if (s > 17'sd32767)
            return MET_MAX;
        else if (s < -17'sd32768)
            return MET_MIN;
        else
            return s[MW-1:0];
    endfunction

    function automatic metric_t sat_add(metric_t a, metric_t b);
        logic signed [MW:0] s;
        s = {a[MW-1], a} + {b[MW-1], b};
        return clamp17(s);
    endfunction

    function automatic metric_t sat_sub(metric_t a, metric_t b);
        logic signed [MW:0] s;
        s = {a[MW-1], a} - {b[MW-1], b};
        return clamp17(s);
    endfunction

endpackage

// File: rtl/acs_deint.sv
module acs_deint
    import acs_pkg::*;
#(
    parameter int S = 64
) (
    input  logic [S*MW-1:0] pm_flat_i,
    output metric_t         even_o [S/2],
    output metric_t         odd_o  [S/2]
);
    localparam int NB = S / 2;

    for (genvar j = 0; j < NB; j++) begin : g_split
        assign even_o[j] = pm_flat_i[(2*j)*MW   +: MW];
        assign odd_o[j]  = pm_flat_i[(2*j+1)*MW +: MW];
    end

endmodule

// File: rtl/acs_bfly_lane.sv
module acs_bfly_lane
    import acs_pkg::*;
(
    input  metric_t   even_i,
    input  metric_t   odd_i,
    input  metric_t   bm_i,
    output bfly_res_t res_o
);
    metric_t c_ep, c_om, c_em, c_op;
    metric_t lo_v, hi_v;
    logic    dlo_v, dhi_v;

    always_comb begin
        c_ep  = sat_add(even_i, bm_i);
        c_om  = sat_sub(odd_i,  bm_i);
        c_em  = sat_sub(even_i, bm_i);
        c_op  = sat_add(odd_i,  bm_i);
        dlo_v = (c_ep >= c_om);
        dhi_v = (c_em >= c_op);
        lo_v  = dlo_v ? c_ep : c_om;
        hi_v  = dhi_v ? c_em : c_op;
        res_o = '{lo: lo_v, hi: hi_v, dlo: dlo_v, dhi: dhi_v};
    end

    // R2 / R3: survivor never below either competitor
    always_comb begin
        a_r2_lo_dominates: assert (lo_v >= c_ep && lo_v >= c_om);
        a_r3_hi_dominates: assert (hi_v >= c_em && hi_v >= c_op);
    end

endmodule

// File: rtl/acs_sched.sv
module acs_sched
    import acs_pkg::*;
#(
    parameter int G  = 4,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          accept_o,
    output logic          run_o,
    output logic [GW-1:0] grp_o,
    output logic          done_o
);
    localparam logic [GW-1:0] GLAST = GW'(G - 1);

    sched_st_t     st;
    logic [GW-1:0] grp;

    assign accept_o = (st == ST_IDLE) && start_i;
    assign run_o    = (st == ST_RUN);
    assign grp_o    = grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            grp    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st  <= ST_RUN;
                        grp <= '0;
                    end
                end
                ST_RUN: begin
                    if (grp == GLAST) begin
                        st     <= ST_IDLE;
                        grp    <= '0;
                        done_o <= 1'b1;
                    end else begin
                        grp <= grp + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6: groups are visited in ascending order, one per cycle
    a_r6_grp_steps: assert property (@(posedge clk) disable iff (rst)
        (run_o && grp != GLAST) |=> (run_o && grp == $past(grp) + 1'b1));

    // R6: a run always begins at group zero
    a_r6_grp_start: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (run_o && grp == '0));

endmodule

// File: rtl/acs_butterfly_array.sv
module acs_butterfly_array
    import acs_pkg::*;
#(
    parameter int K     = 7,
    parameter int LANES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [(1<<(K-1))*16-1:0] pm_i,
    input  logic [(1<<(K-2))*16-1:0] bm_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [(1<<(K-1))*16-1:0] pm_o,
    output logic [(1<<(K-1))-1:0]    dec_o
);
    localparam int S  = 1 << (K - 1);
    localparam int NB = S / 2;
    localparam int L  = (LANES > NB) ? NB : LANES;
    localparam int G  = NB / L;
    localparam int GW = (G > 1) ? $clog2(G) : 1;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic            accept, run;
    logic [GW-1:0]   grp;
    logic [S*MW-1:0] cap_pm;
    logic [NB*MW-1:0] cap_bm;

    metric_t   ev_w [NB];
    metric_t   od_w [NB];
    metric_t   bm_w [NB];
    metric_t   pm_q [S];
    logic [S-1:0] dec_q;

    logic [IW-1:0] idx [L];
    bfly_res_t     res [L];

    acs_sched #(.G(G), .GW(GW)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .run_o    (run),
        .grp_o    (grp),
        .done_o   (done_o)
    );

    assign busy_o = run;

    // operand capture: frozen for the whole run
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pm <= '0;
            cap_bm <= '0;
        end else if (accept) begin
            cap_pm <= pm_i;
            cap_bm <= bm_i;
        end
    end

    acs_deint #(.S(S)) u_deint (
        .pm_flat_i (cap_pm),
        .even_o    (ev_w),
        .odd_o     (od_w)
    );

    for (genvar j = 0; j < NB; j++) begin : g_bm
        assign bm_w[j] = cap_bm[j*MW +: MW];
    end

    for (genvar l = 0; l < L; l++) begin : g_lane
        assign idx[l] = IW'(32'(grp) * L + l);

        acs_bfly_lane u_lane (
            .even_i (ev_w[idx[l]]),
            .odd_i  (od_w[idx[l]]),
            .bm_i   (bm_w[idx[l]]),
            .res_o  (res[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < S; i++) pm_q[i] <= '0;
            dec_q <= '0;
        end else if (run) begin
            for (int l = 0; l < L; l++) begin
                pm_q[int'(idx[l])]       <= res[l].lo;
                pm_q[int'(idx[l]) + NB]  <= res[l].hi;
                dec_q[int'(idx[l])]      <= res[l].dlo;
                dec_q[int'(idx[l]) + NB] <= res[l].dhi;
            end
        end
    end

    for (genvar i = 0; i < S; i++) begin : g_out
        assign pm_o[i*MW +: MW] = pm_q[i];
    end
    assign dec_o = dec_q;

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: the end of every run is flagged by done
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R7: captured operands do not move during a run
    a_r7_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(cap_pm) && $stable(cap_bm)));

    // R6: results stay put while idle
    a_r6_results_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> ($stable(pm_o) && $stable(dec_o)));

endmodule

// File: tb/acs_butterfly_array_tb.sv
`timescale 1ns/1ps
module acs_butterfly_array_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    always #2.5 clk = ~clk;

    logic [1023:0] pm_b_i, pm_b_o;
    logic [511:0]  bm_b_i;
    logic [63:0]   dec_b;
    logic          busy_b, done_b;
    logic [255:0]  pm_s_i, pm_s_o;
    logic [127:0]  bm_s_i;
    logic [15:0]   dec_s;
    logic          busy_s, done_s;

    acs_butterfly_array #(.K(7), .LANES(8)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .pm_i(pm_b_i), .bm_i(bm_b_i),
        .busy_o(busy_b), .done_o(done_b), .pm_o(pm_b_o), .dec_o(dec_b));

    acs_butterfly_array #(.K(5), .LANES(8)) u_dut_k5 (
        .clk(clk), .rst(rst), .start_i(start), .pm_i(pm_s_i), .bm_i(bm_s_i),
        .busy_o(busy_s), .done_o(done_s), .pm_o(pm_s_o), .dec_o(dec_s));

    int checks = 0;
    int fails  = 0;
    int ta_pm [64];
    int ta_bm [32];
    int ex_pm_b [64];
    int ex_dc_b [64];
    int ex_pm_s [16];
    int ex_dc_s [16];
    logic [31:0] seed = 32'h1234_5678;

    function automatic int sat(int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:8]) - 32768;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model();
        for (int s = 16; s <= 64; s += 48) begin
            for (int j = 0; j < s/2; j++) begin
                int e, o, b, a1, a2, h1, h2;
                e  = ta_pm[2*j]; o = ta_pm[2*j+1]; b = ta_bm[j];
                a1 = sat(e + b); a2 = sat(o - b);
                h1 = sat(e - b); h2 = sat(o + b);
                if (s == 64) begin
                    ex_pm_b[j]      = (a1 >= a2) ? a1 : a2;
                    ex_dc_b[j]      = (a1 >= a2) ? 1 : 0;
                    ex_pm_b[j + 32] = (h1 >= h2) ? h1 : h2;
                    ex_dc_b[j + 32] = (h1 >= h2) ? 1 : 0;
                end else begin
                    ex_pm_s[j]     = (a1 >= a2) ? a1 : a2;
                    ex_dc_s[j]     = (a1 >= a2) ? 1 : 0;
                    ex_pm_s[j + 8] = (h1 >= h2) ? h1 : h2;
                    ex_dc_s[j + 8] = (h1 >= h2) ? 1 : 0;
                end
            end
        end
    endtask

    task automatic pack();
        for (int i = 0; i < 64; i++) pm_b_i[16*i +: 16] = 16'(ta_pm[i]);
        for (int j = 0; j < 32; j++) bm_b_i[16*j +: 16] = 16'(ta_bm[j]);
        for (int i = 0; i < 16; i++) pm_s_i[16*i +: 16] = 16'(ta_pm[i]);
        for (int j = 0; j < 8; j++)  bm_s_i[16*j +: 16] = 16'(ta_bm[j]);
    endtask

    task automatic run_case(string tlo, string thi, string tdc, bit ign);
        string tt;
        tt = ign ? "R7" : "R6";
        model();
        pack();
        @(negedge clk);
        start = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1 && ign) begin
                for (int i = 0; i < 64; i++) ta_pm[i] = rnd16();
                for (int j = 0; j < 32; j++) ta_bm[j] = rnd16();
                pack();
            end else begin
                start = 1'b0;
            end
            chk(tt, "done k7", int'(done_b), (k == 5) ? 1 : 0);
            chk(tt, "busy k7", int'(busy_b), (k < 5) ? 1 : 0);
            chk(tt, "done k5", int'(done_s), (k == 2) ? 1 : 0);
            chk(tt, "busy k5", int'(busy_s), (k < 2) ? 1 : 0);
        end
        for (int j = 0; j < 32; j++) begin
            chk(tlo, "pm lo k7", int'($signed(pm_b_o[16*j +: 16])), ex_pm_b[j]);
            chk(thi, "pm hi k7", int'($signed(pm_b_o[16*(j+32) +: 16])), ex_pm_b[j+32]);
            chk(tdc, "dec lo k7", int'(dec_b[j]), ex_dc_b[j]);
            chk(tdc, "dec hi k7", int'(dec_b[j+32]), ex_dc_b[j+32]);
        end
        for (int j = 0; j < 8; j++) begin
            chk(tlo, "pm lo k5", int'($signed(pm_s_o[16*j +: 16])), ex_pm_s[j]);
            chk(thi, "pm hi k5", int'($signed(pm_s_o[16*(j+8) +: 16])), ex_pm_s[j+8]);
            chk(tdc, "dec lo k5", int'(dec_s[j]), ex_dc_s[j]);
            chk(tdc, "dec hi k5", int'(dec_s[j+8]), ex_dc_s[j+8]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        pm_b_i = '0; bm_b_i = '0; pm_s_i = '0; bm_s_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk("R8", "busy k7", int'(busy_b), 0);
        chk("R8", "done k7", int'(done_b), 0);
        chk("R8", "pm k7 zero", int'(pm_b_o != '0), 0);
        chk("R8", "dec k7 zero", int'(dec_b != '0), 0);
        chk("R8", "busy k5", int'(busy_s), 0);
        chk("R8", "pm k5 zero", int'(pm_s_o != '0), 0);

        // R4: all ties, every decision selects the even predecessor
        for (int i = 0; i < 64; i++) ta_pm[i] = 0;
        for (int j = 0; j < 32; j++) ta_bm[j] = 0;
        run_case("R4", "R4", "R4", 1'b0);

        // R5: distinct ramp exposes any pairing or placement error
        for (int i = 0; i < 64; i++) ta_pm[i] = i * 97 - 3000;
        for (int j = 0; j < 32; j++) ta_bm[j] = j * 13 - 200;
        run_case("R5", "R5", "R5", 1'b0);

        // R1: saturation at both limits
        for (int j = 0; j < 32; j++) begin
            case (j % 4)
                0: begin ta_pm[2*j] = 32000;  ta_pm[2*j+1] = -32000; ta_bm[j] = 32767;  end
                1: begin ta_pm[2*j] = -32768; ta_pm[2*j+1] = 32767;  ta_bm[j] = -32768; end
                2: begin ta_pm[2*j] = 32767;  ta_pm[2*j+1] = 32767;  ta_bm[j] = 32767;  end
                default: begin ta_pm[2*j] = -32768; ta_pm[2*j+1] = -32768; ta_bm[j] = 1; end
            endcase
        end
        run_case("R1", "R1", "R1", 1'b0);

        // R4: non-zero ties on the lower candidates, strict loss on the upper
        for (int j = 0; j < 32; j++) begin
            ta_pm[2*j] = 100 + j; ta_pm[2*j+1] = 300 + j; ta_bm[j] = 100;
        end
        run_case("R2", "R3", "R4", 1'b0);

        // R2 / R3: pseudo-random patterns
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 64; i++) ta_pm[i] = rnd16();
            for (int j = 0; j < 32; j++) ta_bm[j] = (n < 2) ? (rnd16() / 64) : rnd16();
            run_case("R2", "R3", "R4", 1'b0);
        end

        // R7: start held and inputs changed during the run
        for (int i = 0; i < 64; i++) ta_pm[i] = rnd16() / 4;
        for (int j = 0; j < 32; j++) ta_bm[j] = rnd16() / 8;
        run_case("R7", "R7", "R7", 1'b1);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule